// File: doc/BRIEF.md
# Clause 22 Management Frame Controller

This block lets a host CPU read and write PHY registers over a two-wire management link (MDC clock, MDIO data). The host sees six word-addressed registers on a simple write-strobe bus with a combinational read path. Software loads the PHY and register numbers into the address register. A write to the write-data register then sends a write frame. A rising read-request bit in the command register sends a read frame. The returned value appears in the read-data register once a not-valid indicator clears.

A frame is an optional 32-bit run of ones, then start `01`, opcode (`10` read, `01` write), five PHY address bits, five register bits, a two-bit turnaround and sixteen data bits, all MSB first. MDC is derived from the register clock through a programmable divider and runs only while a frame is in flight. The MDIO output is split into a data bit and an output enable, so the pad tristate can sit outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset all six registers read 0, MDC is low and the MDIO output enable is low. Indicator bit 1 (scan stub) always reads 0, even after command bit 1 is written.
- R2: Writing the write-data register (offset 3) sends a frame: start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 written bits, all MSB first.
- R3: Command register (offset 1) bit 0 starts a read frame only when a write changes it from 0 to 1. Writing 1 while it already holds 1 starts nothing.
- R4: In a read frame (opcode 10) the output enable drops from the first turnaround bit to the end. The 16 data bits are sampled and shown in the read-data register (offset 4, bits [15:0]). Indicator register (offset 5) bit 2 stays 1 from the start of the read until the data is captured.
- R5: Configuration (offset 0) bit 4 = 0 puts 32 ones before the start bits, for 64 MDC cycles per frame. Bit 4 = 1 omits them, for 32 MDC cycles.
- R6: Configuration bits [2:0] set the MDC period. Codes 0 to 7 give 4, 4, 6, 8, 10, 14, 20 and 28 register clocks, with equal high and low halves.
- R7: MDIO data and enable change only when MDC falls and stay stable while MDC is high. Read data is sampled when MDC rises.
- R8: Indicator bit 0 (busy) is 1 from the clock after an accepted command until one clock after the last bit. A data write or read request made while busy is ignored.
- R9: While configuration bit 31 is 1, any frame is aborted, busy and not-valid read 0, MDC and the enable stay low, and no command is accepted.
- R10: The address register (offset 2) holds the PHY address in bits [12:8] and the register number in bits [4:0]. Both go into every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register word select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | MDIO line value from the pad |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
Two cases are hard to reach from the ports. One is the read turnaround, where control of the line passes between block and PHY. The other is an abort in the middle of a frame. A bench PHY model tracks the frame bit by bit on MDC edges. It detects the start pattern and decodes the opcode. On a read it releases the line for one turnaround bit, then drives a zero and the sixteen data bits on falling edges, and it flags any rise on which the block still drives. The abort case starts a read with the slowest useful divider, sets the reset bit partway through, and then proves that the next write frame still works.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int HDR_BITS   = 14;   // start + opcode + phy + reg
    localparam int DATA_BITS  = 16;
    localparam int DATA_FIRST = FRAME_BITS - DATA_BITS;
    localparam int BIT_CNT_W  = $clog2(FRAME_BITS);
    localparam int HALF_W     = 4;

    localparam logic [2:0] SEL_CFG  = 3'd0;
    localparam logic [2:0] SEL_CMD  = 3'd1;
    localparam logic [2:0] SEL_ADDR = 3'd2;
    localparam logic [2:0] SEL_WDAT = 3'd3;
    localparam logic [2:0] SEL_RDAT = 3'd4;
    localparam logic [2:0] SEL_IND  = 3'd5;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_PRE,
        FS_BODY,
        FS_DONE
    } fsm_t;

    typedef struct packed {
        logic       mgmt_rst;
        logic       no_pre;
        logic [2:0] clk_sel;
    } cfg_t;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regn;
    } target_t;

    typedef struct packed {
        logic                 is_read;
        logic                 no_pre;
        target_t              tgt;
        logic [DATA_BITS-1:0] wdata;
    } cmd_t;

    // Half of the MDC period in register clocks for each select code.
    function automatic logic [HALF_W-1:0] half_period(input logic [2:0] sel);
        case (sel)
            3'd0, 3'd1: half_period = 4'd2;
            3'd2:       half_period = 4'd3;
            3'd3:       half_period = 4'd4;
            3'd4:       half_period = 4'd5;
            3'd5:       half_period = 4'd7;
            3'd6:       half_period = 4'd10;
            default:    half_period = 4'd14;
        endcase
    endfunction

    // Body of a frame after the preamble, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] frame_word(input cmd_t c);
        frame_word = {2'b01,
                      c.is_read ? 2'b10 : 2'b01,
                      c.tgt.phy,
                      c.tgt.regn,
                      c.is_read ? 2'b00 : 2'b10,
                      c.is_read ? {DATA_BITS{1'b0}} : c.wdata};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_mgmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] sel,
    output logic       mdc,
    output logic       rise_stb,
    output logic       fall_stb
);

    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] cnt_q;
    logic              wrap;

    assign wrap     = (cnt_q == half_q - HALF_W'(1));
    assign rise_stb = en && wrap && !mdc;
    assign fall_stb = en && wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            mdc    <= 1'b0;
            half_q <= half_period(sel);   // ratio is frozen for a frame
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  cmd_t                 cmd,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_in,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic                 busy,
    output logic                 div_en,
    output logic                 done_rd,
    output logic [DATA_BITS-1:0] rd_data
);

    fsm_t                  state_q;
    logic [BIT_CNT_W-1:0]  cnt_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  rd_q;
    logic [DATA_BITS-1:0]  rsh_q;
    logic                  in_pre;
    logic                  in_body;

    assign in_pre  = (state_q == FS_PRE);
    assign in_body = (state_q == FS_BODY);
    assign mdio_oe  = in_pre || (in_body && (!rd_q || cnt_q < BIT_CNT_W'(HDR_BITS)));
    assign mdio_out = mdio_oe && (in_pre || sh_q[FRAME_BITS-1]);
    assign busy     = (state_q != FS_IDLE);
    assign div_en   = in_pre || in_body;
    assign done_rd  = (state_q == FS_DONE) && rd_q;
    assign rd_data  = rsh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            rd_q    <= 1'b0;
            rsh_q   <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (start) begin
                        rd_q    <= cmd.is_read;
                        sh_q    <= frame_word(cmd);
                        cnt_q   <= '0;
                        state_q <= cmd.no_pre ? FS_BODY : FS_PRE;
                    end
                end
                FS_PRE: begin
                    if (fall_stb) begin
                        if (cnt_q == BIT_CNT_W'(PRE_BITS - 1)) begin
                            cnt_q   <= '0;
                            state_q <= FS_BODY;
                        end else begin
                            cnt_q <= cnt_q + BIT_CNT_W'(1);
                        end
                    end
                end
                FS_BODY: begin
                    if (rise_stb && rd_q && cnt_q >= BIT_CNT_W'(DATA_FIRST)) begin
                        rsh_q <= {rsh_q[DATA_BITS-2:0], mdio_in};
                    end
                    if (fall_stb) begin
                        if (cnt_q == BIT_CNT_W'(FRAME_BITS - 1)) begin
                            state_q <= FS_DONE;
                        end else begin
                            cnt_q <= cnt_q + BIT_CNT_W'(1);
                            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           reg_sel,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 busy,
    input  logic                 done_rd,
    input  logic [DATA_BITS-1:0] rd_data,
    output logic                 start,
    output cmd_t                 cmd,
    output cfg_t                 cfg,
    output logic                 not_valid
);

    cfg_t                 cfg_q;
    target_t              tgt_q;
    logic [1:0]           cmd_q;
    logic [DATA_BITS-1:0] wdat_q;
    logic [DATA_BITS-1:0] rdat_q;
    logic                 nv_q;
    logic                 accept;
    logic                 start_wr;
    logic                 start_rd;

    assign accept   = !busy && !cfg_q.mgmt_rst;
    assign start_wr = reg_wr && reg_sel == SEL_WDAT && accept;
    assign start_rd = reg_wr && reg_sel == SEL_CMD && reg_wdata[0] && !cmd_q[0] && accept;
    assign start    = start_wr || start_rd;

    always_comb begin
        cmd.is_read = start_rd;
        cmd.no_pre  = cfg_q.no_pre;
        cmd.tgt     = tgt_q;
        cmd.wdata   = reg_wdata[DATA_BITS-1:0];
    end

    assign cfg       = cfg_q;
    assign not_valid = nv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            tgt_q  <= '0;
            cmd_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            nv_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_CFG:  cfg_q  <= '{mgmt_rst: reg_wdata[31],
                                          no_pre:   reg_wdata[4],
                                          clk_sel:  reg_wdata[2:0]};
                    SEL_CMD:  cmd_q  <= reg_wdata[1:0];
                    SEL_ADDR: tgt_q  <= '{phy: reg_wdata[12:8], regn: reg_wdata[4:0]};
                    SEL_WDAT: wdat_q <= reg_wdata[DATA_BITS-1:0];
                    default: ;
                endcase
            end
            if (done_rd) rdat_q <= rd_data;
            if (cfg_q.mgmt_rst)  nv_q <= 1'b0;
            else if (start_rd)   nv_q <= 1'b1;
            else if (done_rd)    nv_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CFG:  reg_rdata = {cfg_q.mgmt_rst, 26'd0, cfg_q.no_pre, 1'b0, cfg_q.clk_sel};
            SEL_CMD:  reg_rdata = {30'd0, cmd_q};
            SEL_ADDR: reg_rdata = {19'd0, tgt_q.phy, 3'd0, tgt_q.regn};
            SEL_WDAT: reg_rdata = {16'd0, wdat_q};
            SEL_RDAT: reg_rdata = {16'd0, rdat_q};
            SEL_IND:  reg_rdata = {29'd0, nv_q, 1'b0, busy};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe
);

    logic                 busy;
    logic                 not_valid;
    logic                 mgmt_rst;
    logic                 eng_rst;
    logic                 start;
    cmd_t                 cmd;
    cfg_t                 cfg;
    logic                 div_en;
    logic                 rise_stb;
    logic                 fall_stb;
    logic                 done_rd;
    logic [DATA_BITS-1:0] rd_data;

    assign mgmt_rst = cfg.mgmt_rst;
    assign eng_rst  = rst || mgmt_rst;

    mdio_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done_rd   (done_rd),
        .rd_data   (rd_data),
        .start     (start),
        .cmd       (cmd),
        .cfg       (cfg),
        .not_valid (not_valid)
    );

    mdio_clk_div u_div (
        .clk      (clk),
        .rst      (eng_rst),
        .en       (div_en),
        .sel      (cfg.clk_sel),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (eng_rst),
        .start    (start),
        .cmd      (cmd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .div_en   (div_en),
        .done_rd  (done_rd),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic reg_wr,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe,
    input logic busy,
    input logic not_valid,
    input logic mgmt_rst
);

    // R7: line only moves while the clock is low
    assert_mdio_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R8: an idle engine leaves the link quiet
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R8: a frame begins only after a bus write
    assert_start_by_write_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr));

    // R4: unread data exists only inside a running frame
    assert_nv_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        not_valid |-> busy);

    // R9: management reset clears the indicators
    assert_mgmt_clear_R9: assert property (@(posedge clk) disable iff (rst)
        mgmt_rst |=> (!busy && !not_valid));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .not_valid (not_valid),
    .mgmt_rst  (mgmt_rst)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  div;
        logic        nopre;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wval;
        logic [15:0] rval;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 1'b0, 5'd8,  5'd0,  16'hA5C3, 16'h1234},
        '{3'd1, 1'b1, 5'd9,  5'd17, 16'h0001, 16'h8000},
        '{3'd2, 1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
        '{3'd5, 1'b1, 5'd0,  5'd1,  16'h8000, 16'hFFFF},
        '{3'd7, 1'b0, 5'd30, 5'd20, 16'h5A5A, 16'hC001},
        '{3'd3, 1'b1, 5'd21, 5'd10, 16'h0000, 16'h6B2D}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_sel;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_in;
    logic        mdio_out;
    logic        mdio_oe;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // PHY model state
    logic [15:0] phy_regs [32];
    logic        phy_oe = 1'b0;
    logic        phy_bit = 1'b1;
    int          pst = 0;
    logic        prev = 1'b1;
    logic [11:0] hdr;
    int          hcnt, rcnt, wcnt;
    logic [17:0] wsh;
    logic [15:0] rd_word;
    int          write_frames = 0, read_frames = 0;
    logic [4:0]  last_w_phy, last_w_reg, last_r_phy;
    logic [1:0]  last_w_ta;
    logic [15:0] last_w_data;
    int          oe_viol = 0;
    int          rises = 0;
    int          last_rise = -1, pmin = 1000, pmax = 0;

    assign mdio_in = phy_oe ? phy_bit : 1'b1;

    mdio_mgmt_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    always @(posedge mdc) begin : phy_rise
        logic b;
        b = mdio_oe ? mdio_out : mdio_in;
        rises++;
        if (last_rise >= 0) begin
            if (cyc - last_rise < pmin) pmin = cyc - last_rise;
            if (cyc - last_rise > pmax) pmax = cyc - last_rise;
        end
        last_rise = cyc;
        case (pst)
            0: begin
                if (!prev && b) begin pst = 1; hcnt = 0; end
                prev = b;
            end
            1: begin
                hdr = {hdr[10:0], b};
                hcnt++;
                if (hcnt == 12) begin
                    if (hdr[11:10] == 2'b10) begin
                        pst = 2; rcnt = 0;
                        last_r_phy = hdr[9:5];
                        rd_word = phy_regs[hdr[4:0]];
                    end else begin
                        pst = 3; wcnt = 0;
                    end
                end
            end
            2: begin
                if (mdio_oe) oe_viol++;
                rcnt++;
                if (rcnt == 18) begin pst = 0; prev = 1'b1; read_frames++; end
            end
            default: begin
                wsh = {wsh[16:0], b};
                wcnt++;
                if (wcnt == 18) begin
                    last_w_phy  = hdr[9:5];
                    last_w_reg  = hdr[4:0];
                    last_w_ta   = wsh[17:16];
                    last_w_data = wsh[15:0];
                    phy_regs[hdr[4:0]] = wsh[15:0];
                    write_frames++;
                    pst = 0; prev = 1'b1;
                end
            end
        endcase
    end

    always @(negedge mdc) begin
        if (pst == 2) begin
            if (rcnt == 0) phy_oe = 1'b0;
            else if (rcnt == 1) begin phy_oe = 1'b1; phy_bit = 1'b0; end
            else if (rcnt <= 17) begin phy_oe = 1'b1; phy_bit = rd_word[17 - rcnt]; end
        end else begin
            phy_oe = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(3'd5, v);
            if (!v[0]) return;
        end
    endtask

    function automatic int ratio(input logic [2:0] d);
        case (d)
            3'd0, 3'd1: return 4;
            3'd2: return 6;
            3'd3: return 8;
            3'd4: return 10;
            3'd5: return 14;
            3'd6: return 20;
            default: return 28;
        endcase
    endfunction

    task automatic clear_meas();
        rises = 0; last_rise = -1; pmin = 1000; pmax = 0;
    endtask

    initial begin : main
        logic [31:0] v;
        int wf, rf;
        for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
        rst = 1'b1; reg_wr = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            chk("R1", "register after reset", v, 32'h0);
        end
        chk("R1", "mdc after reset", {31'd0, mdc}, 32'h0);
        chk("R1", "mdio_oe after reset", {31'd0, mdio_oe}, 32'h0);
        wr(3'd1, 32'h2);
        rd(3'd5, v);
        chk("R1", "scan indicator stub", {31'd0, v[1]}, 32'h0);
        wr(3'd1, 32'h0);

        // Table walk: write then read under each setting
        foreach (VECS[k]) begin
            wr(3'd0, {27'd0, VECS[k].nopre, 1'b0, VECS[k].div});
            wr(3'd2, {19'd0, VECS[k].phy, 3'd0, VECS[k].regn});
            rd(3'd2, v);
            chk("R10", "address readback", v, {19'd0, VECS[k].phy, 3'd0, VECS[k].regn});
            clear_meas();
            wf = write_frames;
            wr(3'd3, {16'd0, VECS[k].wval});
            rd(3'd5, v);
            chk("R8", "busy right after data write", {31'd0, v[0]}, 32'h1);
            wait_idle();
            chk("R2", "write frame count", write_frames - wf, 1);
            chk("R2", "write data (R7 timing)", {16'd0, last_w_data}, {16'd0, VECS[k].wval});
            chk("R10", "write phy address", {27'd0, last_w_phy}, {27'd0, VECS[k].phy});
            chk("R10", "write register number", {27'd0, last_w_reg}, {27'd0, VECS[k].regn});
            chk("R2", "write turnaround", {30'd0, last_w_ta}, 32'h2);
            chk("R5", "MDC cycles in write frame", rises, VECS[k].nopre ? 32 : 64);
            chk("R6", "shortest MDC period", pmin, ratio(VECS[k].div));
            chk("R6", "longest MDC period", pmax, ratio(VECS[k].div));

            phy_regs[VECS[k].regn] = VECS[k].rval;
            clear_meas();
            rf = read_frames; oe_viol = 0;
            wr(3'd1, 32'h0);
            wr(3'd1, 32'h1);
            rd(3'd5, v);
            chk("R4", "busy and not-valid at read start", v, 32'h5);
            wait_idle();
            chk("R3", "read frame count", read_frames - rf, 1);
            chk("R10", "read phy address", {27'd0, last_r_phy}, {27'd0, VECS[k].phy});
            chk("R4", "drive released after header", oe_viol, 0);
            rd(3'd4, v);
            chk("R4", "read data (R7 sampling)", v, {16'd0, VECS[k].rval});
            rd(3'd5, v);
            chk("R4", "indicators after read", v, 32'h0);
            chk("R5", "MDC cycles in read frame", rises, VECS[k].nopre ? 32 : 64);
        end

        // R8: commands during busy are ignored
        wr(3'd0, 32'h0000_0002);
        wr(3'd2, {19'd0, 5'd4, 3'd0, 5'd3});
        wf = write_frames; rf = read_frames;
        wr(3'd3, 32'h1111);
        wr(3'd3, 32'h2222);
        wr(3'd1, 32'h0);
        wr(3'd1, 32'h1);
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R8", "writes during busy", write_frames - wf, 1);
        chk("R8", "data kept from first write", {16'd0, phy_regs[3]}, 32'h1111);
        chk("R8", "read request during busy", read_frames - rf, 0);
        rd(3'd5, v);
        chk("R8", "indicators after ignored commands", v, 32'h0);

        // R3: writing 1 over 1 starts nothing
        wr(3'd1, 32'h1);
        rd(3'd5, v);
        chk("R3", "no read on repeated 1", {31'd0, v[0]}, 32'h0);
        repeat (100) @(negedge clk);
        chk("R3", "read count after repeated 1", read_frames - rf, 0);

        // R9: management reset aborts a read
        wr(3'd0, 32'h0000_0007);
        wr(3'd1, 32'h0);
        wr(3'd1, 32'h1);
        repeat (300) @(negedge clk);
        rd(3'd5, v);
        chk("R9", "read in flight before abort", v, 32'h5);
        wr(3'd0, 32'h8000_0007);
        @(negedge clk);
        rd(3'd5, v);
        chk("R9", "indicators under mgmt reset", v, 32'h0);
        chk("R9", "mdc and oe under mgmt reset", {30'd0, mdc, mdio_oe}, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd1, 32'h1);
        @(negedge clk);
        rd(3'd5, v);
        chk("R9", "command refused under mgmt reset", v, 32'h0);
        pst = 0; prev = 1'b1; phy_oe = 1'b0;
        wr(3'd0, 32'h0000_0010);
        wf = write_frames;
        wr(3'd3, 32'hBEEF);
        wait_idle();
        chk("R9", "frame after mgmt reset released", write_frames - wf, 1);
        chk("R9", "data after mgmt reset released", {16'd0, phy_regs[3]}, 32'hBEEF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule